// File: doc/BRIEF.md
# Bidirectional Port Datapath with Bypass

This block is the port-side datapath of a two-port buffer that carries traffic in both directions. Ports A and B each run on their own clock. Each has an 18-bit data bus, an enable, a read/write select, a bypass select and an output enable. The block sits between the ports and two external direction queues. Words written on port A go to the A-to-B queue, and words written on port B go to the B-to-A queue. A read on a port loads that port's output register from the head of the queue that flows toward it.

Every control and data input is captured in a register on the port's own clock edge. The queue strobes that follow come from those registers, so the external queue acts on the next edge of the same clock. The queue's read data is expected to show its head word whenever it is not empty.

The bypass select lets a word skip the queues. A bypassed write only loads the input register. A bypassed read copies the opposite port's input register into this port's output register. Neither touches a queue. The output enable is carried as a registered drive flag, and the pad tri-state buffer is left to the chip top.

Top module: `bidir_port_path`

## Requirements
- R1: A synchronous reset of a port, sampled on that port's clock, clears its input register, output register and drive flag to 0. While reset holds, the port's two queue strobes are 0.
- R2: When enable=1, rw=0 (write) and bypass=0 are sampled at an edge, the port's outbound queue push strobe is 1 for exactly the following cycle. During that cycle the push data equals the sampled bus word. Port A pushes into the A-to-B queue and port B pushes into the B-to-A queue.
- R3: A write sampled while the outbound queue reports full raises no push strobe and is dropped.
- R4: When enable=1, rw=1 (read) and bypass=0 are sampled and the inbound queue is not empty, the pop strobe is 1 for the following cycle. At the next edge, the output register loads the queue's head word.
- R5: A read sampled while the inbound queue is empty raises no pop strobe and leaves the output register unchanged.
- R6: An edge with enable=0 raises no strobe and changes neither the input register nor the output register, whatever the bus, rw and bypass inputs hold.
- R7: The drive flag equals the output enable sampled at the previous edge, and the output data is unaffected by the output enable.
- R8: A write sampled with bypass=1 loads the input register but raises no queue strobe.
- R9: A read sampled with bypass=1 raises no pop strobe. At the next edge it loads the output register with the opposite port's input register, whatever the queue state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_en | input | 1 | Port A transfer enable |
| a_rw | input | 1 | Port A direction: 1 read, 0 write |
| a_byp | input | 1 | Port A bypass select |
| a_oe | input | 1 | Port A output enable |
| a_din | input | 18 | Port A bus word in |
| a_dout | output | 18 | Port A output register |
| a_drv | output | 1 | Port A drive flag (registered output enable) |
| ab_wr | output | 1 | A-to-B queue push strobe |
| ab_wdata | output | 18 | A-to-B queue push data |
| ab_full | input | 1 | A-to-B queue full |
| ba_rd | output | 1 | B-to-A queue pop strobe (port A side) |
| ba_rdata | input | 18 | B-to-A queue head word |
| ba_empty | input | 1 | B-to-A queue empty |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_en | input | 1 | Port B transfer enable |
| b_rw | input | 1 | Port B direction: 1 read, 0 write |
| b_byp | input | 1 | Port B bypass select |
| b_oe | input | 1 | Port B output enable |
| b_din | input | 18 | Port B bus word in |
| b_dout | output | 18 | Port B output register |
| b_drv | output | 1 | Port B drive flag (registered output enable) |
| ba_wr | output | 1 | B-to-A queue push strobe |
| ba_wdata | output | 18 | B-to-A queue push data |
| ba_full | input | 1 | B-to-A queue full |
| ab_rd | output | 1 | A-to-B queue pop strobe (port B side) |
| ab_rdata | input | 18 | A-to-B queue head word |
| ab_empty | input | 1 | A-to-B queue empty |

## Verification
A corrupted captured control bit shows up within one cycle of the edge that sampled it. It appears as a push or pop strobe that is missing, extra or misdirected. A stale or wrong input register shows up in the push data of the next write, or in the other port's output one edge after a bypassed read there. Output-register faults appear right after the following edge, as a head word that was never loaded or a held value that changed. Because the bench's own queues feed the strobed words back, a lost or duplicated push shows up later as a wrong word, in the wrong order, on the reading port.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  // Control word captured from a port on each of its clock edges.
  typedef struct packed {
    logic en;
    logic rd;   // 1: read, 0: write
    logic byp;
  } port_ctl_t;

  // Queued write: enabled, write direction, not bypassed, room in queue.
  function automatic logic push_fire(port_ctl_t c, logic full);
    return c.en && !c.rd && !c.byp && !full;
  endfunction

  // Queued read: enabled, read direction, not bypassed, data present.
  function automatic logic pop_fire(port_ctl_t c, logic empty);
    return c.en && c.rd && !c.byp && !empty;
  endfunction

  // Bypassed read: output register takes the opposite input register.
  function automatic logic peer_fire(port_ctl_t c);
    return c.en && c.rd && c.byp;
  endfunction

endpackage

// File: rtl/bdp_in_stage.sv
module bdp_in_stage
  import bdp_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         rw,
  input  logic         byp,
  input  logic [W-1:0] din,
  output port_ctl_t    ctl_q,
  output logic [W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      word_q <= '0;
    end else begin
      ctl_q.en  <= en;
      ctl_q.rd  <= rw;
      ctl_q.byp <= byp;
      if (en) word_q <= din;
    end
  end

  // R6: an unenabled edge leaves the captured word alone.
  a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(word_q));

endmodule

// File: rtl/bdp_out_stage.sv
module bdp_out_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe,
  input  logic         load_head,
  input  logic [W-1:0] head_word,
  input  logic         load_peer,
  input  logic [W-1:0] peer_word,
  output logic [W-1:0] dout,
  output logic         drv
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      drv  <= 1'b0;
    end else begin
      drv <= oe;
      if (load_head)      dout <= head_word;
      else if (load_peer) dout <= peer_word;
    end
  end

  // R1: one edge in reset leaves the output register and flag cleared.
  a_r1_out_clear: assert property (@(posedge clk)
    rst |=> (dout == '0) && !drv);

  // R4: a queued read delivers the head word seen at the pop.
  a_r4_head_load: assert property (@(posedge clk) disable iff (rst)
    load_head |=> dout == $past(head_word));

  // R9: a bypassed read delivers the opposite input register.
  a_r9_peer_load: assert property (@(posedge clk) disable iff (rst)
    load_peer |=> dout == $past(peer_word));

  // R5/R6: without a load event the output register holds.
  a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_head && !load_peer) |=> $stable(dout));

endmodule

// File: rtl/bdp_port.sv
module bdp_port
  import bdp_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         rw,
  input  logic         byp,
  input  logic         oe,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drv,
  output logic         push,
  output logic [W-1:0] push_word,
  input  logic         dst_full,
  output logic         pop,
  input  logic [W-1:0] pop_word,
  input  logic         src_empty,
  input  logic [W-1:0] peer_word,
  output logic [W-1:0] own_word
);

  port_ctl_t    ctl_q;
  logic [W-1:0] word_q;
  logic         peer_ld;

  bdp_in_stage #(.W(W)) u_in (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .rw     (rw),
    .byp    (byp),
    .din    (din),
    .ctl_q  (ctl_q),
    .word_q (word_q)
  );

  // Strobes are suppressed during reset so the queues see nothing.
  assign push      = !rst && push_fire(ctl_q, dst_full);
  assign pop       = !rst && pop_fire(ctl_q, src_empty);
  assign peer_ld   = !rst && peer_fire(ctl_q);
  assign push_word = word_q;
  assign own_word  = word_q;

  bdp_out_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .oe        (oe),
    .load_head (pop),
    .head_word (pop_word),
    .load_peer (peer_ld),
    .peer_word (peer_word),
    .dout      (dout),
    .drv       (drv)
  );

  // R2: a single captured command never pushes and pops together.
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(push && (pop || peer_ld)));

  // R1: reset keeps both queue strobes low.
  a_r1_no_strobe: assert property (@(posedge clk)
    rst |-> !push && !pop);

endmodule

// File: rtl/bidir_port_path.sv
module bidir_port_path #(
  parameter int W = 18
) (
  input  logic         clk_a,
  input  logic         rst_a,
  input  logic         a_en,
  input  logic         a_rw,
  input  logic         a_byp,
  input  logic         a_oe,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_drv,
  output logic         ab_wr,
  output logic [W-1:0] ab_wdata,
  input  logic         ab_full,
  output logic         ba_rd,
  input  logic [W-1:0] ba_rdata,
  input  logic         ba_empty,
  input  logic         clk_b,
  input  logic         rst_b,
  input  logic         b_en,
  input  logic         b_rw,
  input  logic         b_byp,
  input  logic         b_oe,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         b_drv,
  output logic         ba_wr,
  output logic [W-1:0] ba_wdata,
  input  logic         ba_full,
  output logic         ab_rd,
  input  logic [W-1:0] ab_rdata,
  input  logic         ab_empty
);

  logic [W-1:0] a_word;
  logic [W-1:0] b_word;

  bdp_port #(.W(W)) u_port_a (
    .clk       (clk_a),
    .rst       (rst_a),
    .en        (a_en),
    .rw        (a_rw),
    .byp       (a_byp),
    .oe        (a_oe),
    .din       (a_din),
    .dout      (a_dout),
    .drv       (a_drv),
    .push      (ab_wr),
    .push_word (ab_wdata),
    .dst_full  (ab_full),
    .pop       (ba_rd),
    .pop_word  (ba_rdata),
    .src_empty (ba_empty),
    .peer_word (b_word),
    .own_word  (a_word)
  );

  bdp_port #(.W(W)) u_port_b (
    .clk       (clk_b),
    .rst       (rst_b),
    .en        (b_en),
    .rw        (b_rw),
    .byp       (b_byp),
    .oe        (b_oe),
    .din       (b_din),
    .dout      (b_dout),
    .drv       (b_drv),
    .push      (ba_wr),
    .push_word (ba_wdata),
    .dst_full  (ba_full),
    .pop       (ab_rd),
    .pop_word  (ab_rdata),
    .src_empty (ab_empty),
    .peer_word (a_word),
    .own_word  (b_word)
  );

endmodule

// File: tb/bidir_port_path_tb.sv
`timescale 1ns/100ps
module bidir_port_path_tb;

  localparam int W = 18;
  localparam int D = 4;          // depth of each bench queue

  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic a_en = 0, a_rw = 0, a_byp = 0, a_oe = 0;
  logic b_en = 0, b_rw = 0, b_byp = 0, b_oe = 0;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] a_dout, b_dout, ab_wdata, ba_wdata, ab_rdata, ba_rdata;
  logic a_drv, b_drv, ab_wr, ba_wr, ab_rd, ba_rd;
  logic ab_full, ab_empty, ba_full, ba_empty;

  // Bench queues (the block's environment).
  logic [W-1:0] ab_mem [D];
  logic [W-1:0] ba_mem [D];
  int ab_wp = 0, ab_rp = 0, ba_wp = 0, ba_rp = 0;
  assign ab_full  = (ab_wp - ab_rp) == D;
  assign ab_empty = ab_wp == ab_rp;
  assign ba_full  = (ba_wp - ba_rp) == D;
  assign ba_empty = ba_wp == ba_rp;
  assign ab_rdata = ab_mem[ab_rp % D];
  assign ba_rdata = ba_mem[ba_rp % D];

  int total = 0, bad = 0;
  bit done = 0;

  bidir_port_path #(.W(W)) u_dut (
    .clk_a(clk_a), .rst_a(rst_a), .a_en(a_en), .a_rw(a_rw), .a_byp(a_byp),
    .a_oe(a_oe), .a_din(a_din), .a_dout(a_dout), .a_drv(a_drv),
    .ab_wr(ab_wr), .ab_wdata(ab_wdata), .ab_full(ab_full),
    .ba_rd(ba_rd), .ba_rdata(ba_rdata), .ba_empty(ba_empty),
    .clk_b(clk_b), .rst_b(rst_b), .b_en(b_en), .b_rw(b_rw), .b_byp(b_byp),
    .b_oe(b_oe), .b_din(b_din), .b_dout(b_dout), .b_drv(b_drv),
    .ba_wr(ba_wr), .ba_wdata(ba_wdata), .ba_full(ba_full),
    .ab_rd(ab_rd), .ab_rdata(ab_rdata), .ab_empty(ab_empty)
  );

  // A: 100 MHz on integer times; B: other rate, edges offset by 0.3 ns.
  always #5 clk_a = ~clk_a;
  initial begin
    #0.3;
    forever #7 clk_b = ~clk_b;
  end

  // Behavioural reference state per port.
  bit ma_en = 0, ma_rd = 0, ma_byp = 0, ea_drv = 0;
  bit mb_en = 0, mb_rd = 0, mb_byp = 0, eb_drv = 0;
  logic [W-1:0] ma_word = '0, mb_word = '0, ea_dout = '0, eb_dout = '0;
  string ta_tag = "R1", tb_tag = "R1";

  always @(posedge clk_a) begin
    if (ab_wr) begin ab_mem[ab_wp % D] <= ab_wdata; ab_wp <= ab_wp + 1; end
    if (ba_rd) ba_rp <= ba_rp + 1;
    if (rst_a) begin
      ma_en <= 0; ma_rd <= 0; ma_byp <= 0; ma_word <= '0;
      ea_dout <= '0; ea_drv <= 0; ta_tag <= "R1";
    end else begin
      ta_tag <= "R6";
      if (ma_en && ma_rd) begin
        if (ma_byp) begin ea_dout <= mb_word; ta_tag <= "R9"; end
        else if (ba_wp != ba_rp) begin ea_dout <= ba_mem[ba_rp % D]; ta_tag <= "R4"; end
        else ta_tag <= "R5";
      end
      ea_drv <= a_oe;
      ma_en <= a_en; ma_rd <= a_rw; ma_byp <= a_byp;
      if (a_en) ma_word <= a_din;
    end
  end

  always @(posedge clk_b) begin
    if (ba_wr) begin ba_mem[ba_wp % D] <= ba_wdata; ba_wp <= ba_wp + 1; end
    if (ab_rd) ab_rp <= ab_rp + 1;
    if (rst_b) begin
      mb_en <= 0; mb_rd <= 0; mb_byp <= 0; mb_word <= '0;
      eb_dout <= '0; eb_drv <= 0; tb_tag <= "R1";
    end else begin
      tb_tag <= "R6";
      if (mb_en && mb_rd) begin
        if (mb_byp) begin eb_dout <= ma_word; tb_tag <= "R9"; end
        else if (ab_wp != ab_rp) begin eb_dout <= ab_mem[ab_rp % D]; tb_tag <= "R4"; end
        else tb_tag <= "R5";
      end
      eb_drv <= b_oe;
      mb_en <= b_en; mb_rd <= b_rw; mb_byp <= b_byp;
      if (b_en) mb_word <= b_din;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string wr_tag(bit en, bit rd, bit byp, bit full, bit rst);
    if (rst) return "R1";
    if (!en) return "R6";
    if (byp) return "R8";
    if (rd) return "R4";
    if (full) return "R3";
    return "R2";
  endfunction

  // Compare every port A output on each falling edge of clk_a.
  always @(negedge clk_a) if (!done) begin
    bit exp_wr, exp_rd;
    exp_wr = !rst_a && ma_en && !ma_rd && !ma_byp && !((ab_wp - ab_rp) == D);
    exp_rd = !rst_a && ma_en && ma_rd && !ma_byp && (ba_wp != ba_rp);
    check(a_dout === ea_dout, ta_tag, "a_dout", 32'(a_dout), 32'(ea_dout));
    check(a_drv === ea_drv, "R7", "a_drv", 32'(a_drv), 32'(ea_drv));
    check(ab_wr === exp_wr, wr_tag(ma_en, ma_rd, ma_byp, ab_full, rst_a),
          "ab_wr", 32'(ab_wr), 32'(exp_wr));
    if (exp_wr) check(ab_wdata === ma_word, "R2", "ab_wdata", 32'(ab_wdata), 32'(ma_word));
    check(ba_rd === exp_rd, ma_byp ? "R9" : (ma_rd ? "R5" : "R6"),
          "ba_rd", 32'(ba_rd), 32'(exp_rd));
  end

  always @(negedge clk_b) if (!done) begin
    bit exp_wr, exp_rd;
    exp_wr = !rst_b && mb_en && !mb_rd && !mb_byp && !((ba_wp - ba_rp) == D);
    exp_rd = !rst_b && mb_en && mb_rd && !mb_byp && (ab_wp != ab_rp);
    check(b_dout === eb_dout, tb_tag, "b_dout", 32'(b_dout), 32'(eb_dout));
    check(b_drv === eb_drv, "R7", "b_drv", 32'(b_drv), 32'(eb_drv));
    check(ba_wr === exp_wr, wr_tag(mb_en, mb_rd, mb_byp, ba_full, rst_b),
          "ba_wr", 32'(ba_wr), 32'(exp_wr));
    if (exp_wr) check(ba_wdata === mb_word, "R2", "ba_wdata", 32'(ba_wdata), 32'(mb_word));
    check(ab_rd === exp_rd, mb_byp ? "R9" : (mb_rd ? "R5" : "R6"),
          "ab_rd", 32'(ab_rd), 32'(exp_rd));
  end

  task automatic a_cyc(input bit en, input bit rw, input bit byp, input bit oe,
                       input logic [W-1:0] d);
    @(negedge clk_a);
    a_en = en; a_rw = rw; a_byp = byp; a_oe = oe; a_din = d;
  endtask

  task automatic b_cyc(input bit en, input bit rw, input bit byp, input bit oe,
                       input logic [W-1:0] d);
    @(negedge clk_b);
    b_en = en; b_rw = rw; b_byp = byp; b_oe = oe; b_din = d;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state observed on the first few falling edges.
    repeat (4) @(negedge clk_a);
    repeat (3) @(negedge clk_b);
    rst_a = 0; @(negedge clk_b); rst_b = 0;
    // R2/R4: three words A->B, read on B.
    for (int i = 0; i < 3; i++) a_cyc(1, 0, 0, 1, 18'h1000 + 18'(i));
    a_cyc(0, 0, 0, 1, 18'h3ffff);
    for (int i = 0; i < 4; i++) b_cyc(1, 1, 0, 1, '0);   // 4th read hits empty (R5)
    b_cyc(0, 1, 0, 1, 18'h2aaaa);
    // R3: overfill A->B, then drain with extra empty reads.
    for (int i = 0; i < 7; i++) a_cyc(1, 0, 0, 0, 18'h2000 + 18'(i));
    a_cyc(0, 0, 0, 0, '0);
    for (int i = 0; i < 6; i++) b_cyc(1, 1, 0, 0, '0);
    b_cyc(0, 0, 0, 0, '0);
    // B->A direction, including full and empty corners.
    for (int i = 0; i < 5; i++) b_cyc(1, 0, 0, 1, 18'h0300 + 18'(i));
    b_cyc(0, 0, 0, 1, '0);
    for (int i = 0; i < 6; i++) a_cyc(1, 1, 0, 1, '0);
    a_cyc(0, 0, 0, 1, '0);
    // R8/R9: bypassed write on A, bypassed read on B (and reverse).
    a_cyc(1, 0, 1, 1, 18'h15a5a);
    a_cyc(0, 0, 0, 1, 18'h0ffff);           // R6: bus changes, enable low
    b_cyc(1, 1, 1, 1, '0);
    b_cyc(0, 1, 1, 0, '0);
    b_cyc(1, 0, 1, 1, 18'h0c3c3);
    b_cyc(0, 0, 0, 1, '0);
    a_cyc(1, 1, 1, 1, '0);
    a_cyc(0, 1, 1, 1, 18'h12345);
    // R6: a burst of disabled edges with busy buses.
    for (int i = 0; i < 5; i++) a_cyc(0, i[0], i[1], i[0], 18'(i * 7919));
    // Mixed traffic on both ports at once, with a mid-run reset of A.
    fork
      for (int i = 0; i < 400; i++) begin
        int r;
        r = $urandom;
        if (i == 200) rst_a = 1;
        if (i == 203) rst_a = 0;
        a_cyc(r[0] | r[1], r[2], r[5] & r[6] & r[7], r[3], 18'(r >> 8));
      end
      for (int i = 0; i < 300; i++) begin
        int r;
        r = $urandom;
        b_cyc(r[0] | r[1], r[2], r[5] & r[6] & r[7], r[3], 18'(r >> 8));
      end
    join
    a_cyc(0, 0, 0, 0, '0);
    b_cyc(0, 0, 0, 0, '0);
    repeat (3) @(negedge clk_b);
    finish_run();
  end

endmodule